// File: doc/BRIEF.md
# Five-Stage In-Order Datapath Core

This block is a compact in-order core that carries every instruction through five stages: fetch, decode with register read, execute, memory access, and register write-back. A pipeline register sits between each pair of neighbouring stages, and all of these registers move forward together on every clock. The machine has eight 32-bit registers and four operations: add, nand, load word and store word.

Instruction and data storage are small word arrays inside the core. While reset is held, a testbench or loader fills them through two load ports. Once reset is released, the PC starts at zero and the core fetches one instruction per cycle. Debug ports show the PC, any one register and any one data word.

The core has no hazard detection, forwarding, stalls or control flow. A program must therefore keep dependent instructions far enough apart. The register file makes a value written in write-back readable by decode in the same cycle. Because of this, a consumer that sits three slots after its producer already sees the new value.

Top module: `pipe5_core`

## Requirements
- R1: The instruction held at word k of instruction storage has its register effect visible on the debug register port after the (k+5)-th rising edge following reset release. All stage registers advance on every clock.
- R2: The PC is 0 after reset and grows by 4 on every clock. The fetch word index is PC bits [IAW+1:2], where IAW is log2 of the instruction depth.
- R3: Opcode 0x00 (bits 31..26) with function 0x20 (bits 5..0) writes rs+rt into rd. The fields are rs in bits 25..21, rt in bits 20..16 and rd in bits 15..11, and only the low three bits of each select a register.
- R4: Opcode 0x00 with function 0x27 writes ~(rs & rt) into rd.
- R5: Opcode 0x23 loads the data word at index (rs + imm)[DAW+1:2] into rt.
- R6: Opcode 0x2B stores rt into the data word at index (rs + imm)[DAW+1:2] and writes no register.
- R7: The 16-bit immediate in bits 15..0 is sign-extended, so negative offsets address below the base register.
- R8: Any other opcode, and opcode 0x00 with any other function code (including the all-zero nop), writes neither a register nor data storage.
- R9: A register written in write-back is returned to a decode read of the same register in the same cycle, so a consumer placed three slots after its producer sees the new value.
- R10: While reset is low, every register reads 0, the PC reads 0 and every stage holds a nop.
- R11: The load ports write storage only while reset is low. Load strobes given while the core runs have no effect.
- R12: The debug ports return the addressed register, the addressed data word and the current PC combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| imem_load_en | input | 1 | Instruction storage load strobe (honoured only in reset) |
| imem_load_idx | input | IAW | Instruction word index for loading |
| imem_load_data | input | 32 | Instruction word to load |
| dmem_load_en | input | 1 | Data storage load strobe (honoured only in reset) |
| dmem_load_idx | input | DAW | Data word index for loading |
| dmem_load_data | input | 32 | Data word to load |
| dbg_reg_idx | input | 3 | Register selected for the debug port |
| dbg_reg_data | output | 32 | Value of the selected register |
| dbg_dmem_idx | input | DAW | Data word selected for the debug port |
| dbg_dmem_data | output | 32 | Value of the selected data word |
| dbg_pc | output | 32 | Current PC |

## Verification
On every cycle, the assertions check several relations. The fetch-stage link value must track the PC. Each stage's destination index must shift into the next stage. A store must never also request a register write. A nop in write-back must never write. A written register must hold its value after the edge. During reset, the PC and stages must be cleared. The bench's scenarios are the only evidence for other behaviour. They show the arithmetic results, the addressing with a negative offset, store-then-load ordering, the same-cycle visibility of a write to a consumer three slots later, and that load strobes are ignored while the core runs. The bench's behavioural model supports this by retiring one instruction per cycle and comparing a rotating register and the PC on every clock.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int XLEN      = 32;
    localparam int REG_AW    = 3;
    localparam int REG_COUNT = 1 << REG_AW;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_LOAD  = 6'h23;
    localparam logic [5:0] OPC_STORE = 6'h2B;
    localparam logic [5:0] FN_ADD    = 6'h20;
    localparam logic [5:0] FN_NAND   = 6'h27;

    typedef enum logic [1:0] {
        K_NOP   = 2'd0,
        K_ALU   = 2'd1,
        K_LOAD  = 2'd2,
        K_STORE = 2'd3
    } op_kind_e;

    typedef enum logic {
        F_ADD  = 1'b0,
        F_NAND = 1'b1
    } alu_fn_e;

    typedef struct packed {
        op_kind_e kind;
        alu_fn_e  fn;
        logic     reg_write;
        logic     mem_write;
        logic     wb_from_mem;
    } ctrl_t;

    typedef struct packed {
        logic [XLEN-1:0] instr;
        logic [XLEN-1:0] pc4;
    } fd_reg_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_AW-1:0] dest;
        logic [XLEN-1:0]   imm;
        logic [XLEN-1:0]   a;
        logic [XLEN-1:0]   b;
        logic [XLEN-1:0]   pc4;
    } dx_reg_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_AW-1:0] dest;
        logic [XLEN-1:0]   alu;
        logic [XLEN-1:0]   b;
    } xm_reg_t;

    typedef struct packed {
        ctrl_t             ctrl;
        logic [REG_AW-1:0] dest;
        logic [XLEN-1:0]   mdata;
        logic [XLEN-1:0]   alu;
    } mw_reg_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        fd_reg_t         fd;
        dx_reg_t         dx;
        xm_reg_t         xm;
        mw_reg_t         mw;
    } pipe_state_t;

endpackage

// File: rtl/pipe5_decode.sv
module pipe5_decode
    import pipe5_pkg::*;
(
    input  logic [XLEN-1:0]   instr,
    output ctrl_t             ctrl,
    output logic [REG_AW-1:0] rs,
    output logic [REG_AW-1:0] rt,
    output logic [REG_AW-1:0] dest,
    output logic [XLEN-1:0]   imm
);
    logic [5:0]        opc;
    logic [5:0]        fnc;
    logic [REG_AW-1:0] rd;
    logic              unused_bits;

    assign opc  = instr[31:26];
    assign fnc  = instr[5:0];
    assign rs   = instr[21 +: REG_AW];
    assign rt   = instr[16 +: REG_AW];
    assign rd   = instr[11 +: REG_AW];
    assign imm  = {{(XLEN-16){instr[15]}}, instr[15:0]};
    assign unused_bits = ^{instr[25:21+REG_AW], instr[20:16+REG_AW], instr[15:11+REG_AW]};

    always_comb begin
        ctrl = '{kind: K_NOP, fn: F_ADD, reg_write: 1'b0, mem_write: 1'b0, wb_from_mem: 1'b0};
        dest = rt;
        unique case (opc)
            OPC_RTYPE: begin
                dest = rd;
                if (fnc == FN_ADD) begin
                    ctrl.kind      = K_ALU;
                    ctrl.reg_write = 1'b1;
                end else if (fnc == FN_NAND) begin
                    ctrl.kind      = K_ALU;
                    ctrl.fn        = F_NAND;
                    ctrl.reg_write = 1'b1;
                end
            end
            OPC_LOAD: begin
                ctrl.kind        = K_LOAD;
                ctrl.reg_write   = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OPC_STORE: begin
                ctrl.kind      = K_STORE;
                ctrl.mem_write = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile
    import pipe5_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [REG_AW-1:0] ra_addr,
    output logic [XLEN-1:0]   ra_data,
    input  logic [REG_AW-1:0] rb_addr,
    output logic [XLEN-1:0]   rb_data,
    input  logic [REG_AW-1:0] dbg_addr,
    output logic [XLEN-1:0]   dbg_data
);
    logic [XLEN-1:0] regs_d [REG_COUNT];
    logic [XLEN-1:0] regs_q [REG_COUNT];

    always_comb begin
        regs_d = regs_q;
        if (we) regs_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    // same-cycle visibility of the write-back value to decode reads
    assign ra_data  = (we && waddr == ra_addr) ? wdata : regs_q[ra_addr];
    assign rb_data  = (we && waddr == rb_addr) ? wdata : regs_q[rb_addr];
    assign dbg_data = regs_q[dbg_addr];

    p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> regs_q[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/pipe5_wordmem.sv
module pipe5_wordmem
    import pipe5_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic            clk,
    input  logic            load_en,
    input  logic [AW-1:0]   load_idx,
    input  logic [XLEN-1:0] load_data,
    input  logic            st_en,
    input  logic [AW-1:0]   st_idx,
    input  logic [XLEN-1:0] st_data,
    input  logic [AW-1:0]   rd_idx,
    output logic [XLEN-1:0] rd_data,
    input  logic [AW-1:0]   dbg_idx,
    output logic [XLEN-1:0] dbg_data
);
    logic [XLEN-1:0] mem_d [DEPTH];
    logic [XLEN-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (load_en)    mem_d[load_idx] = load_data;
        else if (st_en) mem_d[st_idx]   = st_data;
    end

    always_ff @(posedge clk) mem_q <= mem_d;

    assign rd_data  = mem_q[rd_idx];
    assign dbg_data = mem_q[dbg_idx];
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_WORDS = 64,
    parameter int DMEM_WORDS = 64,
    localparam int IAW = $clog2(IMEM_WORDS),
    localparam int DAW = $clog2(DMEM_WORDS)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              imem_load_en,
    input  logic [IAW-1:0]    imem_load_idx,
    input  logic [XLEN-1:0]   imem_load_data,
    input  logic              dmem_load_en,
    input  logic [DAW-1:0]    dmem_load_idx,
    input  logic [XLEN-1:0]   dmem_load_data,
    input  logic [REG_AW-1:0] dbg_reg_idx,
    output logic [XLEN-1:0]   dbg_reg_data,
    input  logic [DAW-1:0]    dbg_dmem_idx,
    output logic [XLEN-1:0]   dbg_dmem_data,
    output logic [XLEN-1:0]   dbg_pc
);
    pipe_state_t s_d, s_q;

    logic [XLEN-1:0]   fetch_word;
    ctrl_t             dec_ctrl;
    logic [REG_AW-1:0] dec_rs, dec_rt, dec_dest;
    logic [XLEN-1:0]   dec_imm, rs_val, rt_val;
    logic [XLEN-1:0]   dmem_rd;
    logic [XLEN-1:0]   alu_opb, alu_out;
    logic              rf_we;
    logic [XLEN-1:0]   rf_wdata;
    logic              unused_bits;

    assign unused_bits = ^{s_q.dx.pc4, s_q.pc[XLEN-1:IAW+2], s_q.pc[1:0],
                           s_q.xm.alu[XLEN-1:DAW+2], s_q.xm.alu[1:0]};

    pipe5_wordmem #(.DEPTH(IMEM_WORDS)) u_imem (
        .clk(clk), .load_en(imem_load_en && !rst_n), .load_idx(imem_load_idx),
        .load_data(imem_load_data), .st_en(1'b0), .st_idx('0), .st_data('0),
        .rd_idx(s_q.pc[IAW+1:2]), .rd_data(fetch_word),
        .dbg_idx('0), .dbg_data()
    );

    pipe5_decode u_dec (
        .instr(s_q.fd.instr), .ctrl(dec_ctrl), .rs(dec_rs), .rt(dec_rt),
        .dest(dec_dest), .imm(dec_imm)
    );

    pipe5_regfile u_rf (
        .clk(clk), .rst_n(rst_n), .we(rf_we), .waddr(s_q.mw.dest), .wdata(rf_wdata),
        .ra_addr(dec_rs), .ra_data(rs_val), .rb_addr(dec_rt), .rb_data(rt_val),
        .dbg_addr(dbg_reg_idx), .dbg_data(dbg_reg_data)
    );

    pipe5_wordmem #(.DEPTH(DMEM_WORDS)) u_dmem (
        .clk(clk), .load_en(dmem_load_en && !rst_n), .load_idx(dmem_load_idx),
        .load_data(dmem_load_data), .st_en(s_q.xm.ctrl.mem_write && rst_n),
        .st_idx(s_q.xm.alu[DAW+1:2]), .st_data(s_q.xm.b),
        .rd_idx(s_q.xm.alu[DAW+1:2]), .rd_data(dmem_rd),
        .dbg_idx(dbg_dmem_idx), .dbg_data(dbg_dmem_data)
    );

    // execute-stage operand choice and operation
    assign alu_opb = (s_q.dx.ctrl.kind == K_ALU) ? s_q.dx.b : s_q.dx.imm;
    assign alu_out = (s_q.dx.ctrl.fn == F_NAND) ? ~(s_q.dx.a & alu_opb)
                                                : s_q.dx.a + alu_opb;

    // write-back selection
    assign rf_we    = s_q.mw.ctrl.reg_write;
    assign rf_wdata = s_q.mw.ctrl.wb_from_mem ? s_q.mw.mdata : s_q.mw.alu;

    always_comb begin
        s_d = s_q;
        s_d.pc          = s_q.pc + 32'd4;
        s_d.fd.instr    = fetch_word;
        s_d.fd.pc4      = s_q.pc + 32'd4;
        s_d.dx.ctrl     = dec_ctrl;
        s_d.dx.dest     = dec_dest;
        s_d.dx.imm      = dec_imm;
        s_d.dx.a        = rs_val;
        s_d.dx.b        = rt_val;
        s_d.dx.pc4      = s_q.fd.pc4;
        s_d.xm.ctrl     = s_q.dx.ctrl;
        s_d.xm.dest     = s_q.dx.dest;
        s_d.xm.alu      = alu_out;
        s_d.xm.b        = s_q.dx.b;
        s_d.mw.ctrl     = s_q.xm.ctrl;
        s_d.mw.dest     = s_q.xm.dest;
        s_d.mw.mdata    = dmem_rd;
        s_d.mw.alu      = s_q.xm.alu;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dbg_pc = s_q.pc;

    p_pc_link_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fd.pc4 == s_q.pc);
    p_reset_clear_r10: assert property (@(posedge clk)
        !rst_n |-> (s_q.pc == '0 && s_q.mw.ctrl.kind == K_NOP && s_q.xm.ctrl.kind == K_NOP));
    p_stage_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> s_q.xm.dest == $past(s_q.dx.dest) && s_q.mw.ctrl == $past(s_q.xm.ctrl));
    p_store_no_reg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.xm.ctrl.mem_write |-> !s_q.xm.ctrl.reg_write);
    p_nop_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mw.ctrl.kind == K_NOP) |-> !rf_we);
endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
    localparam int CLK_PERIOD = 10;
    localparam int WORDS      = 64;
    localparam int N_RUN      = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        imem_load_en = 1'b0;
    logic [5:0]  imem_load_idx = '0;
    logic [31:0] imem_load_data = '0;
    logic        dmem_load_en = 1'b0;
    logic [5:0]  dmem_load_idx = '0;
    logic [31:0] dmem_load_data = '0;
    logic [2:0]  dbg_reg_idx = '0;
    logic [31:0] dbg_reg_data;
    logic [5:0]  dbg_dmem_idx = '0;
    logic [31:0] dbg_dmem_data;
    logic [31:0] dbg_pc;

    int checks = 0;
    int failures = 0;
    logic [31:0] prog [WORDS];
    logic [31:0] m_reg [8];
    logic [31:0] m_dmem [WORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe5_core dut (
        .clk(clk), .rst_n(rst_n),
        .imem_load_en(imem_load_en), .imem_load_idx(imem_load_idx), .imem_load_data(imem_load_data),
        .dmem_load_en(dmem_load_en), .dmem_load_idx(dmem_load_idx), .dmem_load_data(dmem_load_data),
        .dbg_reg_idx(dbg_reg_idx), .dbg_reg_data(dbg_reg_data),
        .dbg_dmem_idx(dbg_dmem_idx), .dbg_dmem_data(dbg_dmem_data), .dbg_pc(dbg_pc)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] preload(int i);
        case (i)
            0: return 32'd36;  1: return 32'd8;   2: return 32'd12;  3: return 32'd18;
            4: return 32'd7;   5: return 32'd41;  6: return 32'd22;  7: return 32'hFFFF_FFF0;
            default: return 32'(i * 37 + 5);
        endcase
    endfunction

    // behavioural retirement of one instruction
    task automatic retire(logic [31:0] ins);
        int rs = int'(ins[23:21]);
        int rt = int'(ins[18:16]);
        int rd = int'(ins[13:11]);
        logic [31:0] ea = m_reg[rs] + {{16{ins[15]}}, ins[15:0]};
        if (ins[31:26] == 6'h00 && ins[5:0] == 6'h20)      m_reg[rd] = m_reg[rs] + m_reg[rt];
        else if (ins[31:26] == 6'h00 && ins[5:0] == 6'h27) m_reg[rd] = ~(m_reg[rs] & m_reg[rt]);
        else if (ins[31:26] == 6'h23)                      m_reg[rt] = m_dmem[(ea >> 2) % WORDS];
        else if (ins[31:26] == 6'h2B)                      m_dmem[(ea >> 2) % WORDS] = m_reg[rt];
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_reg(int idx, output logic [31:0] v);
        dbg_reg_idx = 3'(idx);
        #1 v = dbg_reg_data;
    endtask

    task automatic read_dmem(int idx, output logic [31:0] v);
        dbg_dmem_idx = 6'(idx);
        #1 v = dbg_dmem_data;
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] v;
        for (int i = 0; i < WORDS; i++) prog[i] = 32'h0;
        prog[0]  = enc_i(6'h23, 0, 1, 0);
        prog[1]  = enc_i(6'h23, 0, 2, 4);
        prog[2]  = enc_i(6'h23, 0, 4, 16);
        prog[3]  = enc_i(6'h23, 0, 5, 20);
        prog[4]  = enc_i(6'h23, 0, 7, 24);
        prog[8]  = enc_r(1, 2, 3, 6'h20);
        prog[9]  = enc_r(4, 5, 6, 6'h27);
        prog[10] = enc_i(6'h23, 2, 4, 20);
        prog[11] = enc_r(2, 5, 5, 6'h20);
        prog[15] = enc_i(6'h2B, 3, 7, 12);
        prog[16] = enc_i(6'h2B, 3, 6, -4);
        prog[17] = enc_i(6'h3F, 0, 7, 5);
        prog[18] = enc_r(1, 2, 6, 6'h22);
        prog[19] = enc_r(4, 5, 0, 6'h20);
        prog[22] = enc_r(0, 0, 1, 6'h20);
        prog[26] = enc_i(6'h23, 3, 2, -4);
        prog[27] = enc_i(6'h2B, 3, 1, -8);
        for (int i = 0; i < 8; i++) m_reg[i] = '0;
        for (int i = 0; i < WORDS; i++) m_dmem[i] = preload(i);

        // load both storages while reset is held
        for (int i = 0; i < WORDS; i++) begin
            @(negedge clk);
            imem_load_en = 1'b1; imem_load_idx = 6'(i); imem_load_data = prog[i];
            dmem_load_en = 1'b1; dmem_load_idx = 6'(i); dmem_load_data = preload(i);
        end
        @(negedge clk);
        imem_load_en = 1'b0; dmem_load_en = 1'b0;
        @(negedge clk);

        chk("R10 pc in reset", dbg_pc, 32'h0);
        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            chk("R10 register in reset", v, 32'h0);
        end
        read_dmem(5, v);
        chk("R12 loaded data word", v, 32'd41);

        rst_n = 1'b1;
        for (int n = 1; n <= N_RUN; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (n >= 5) retire(prog[n-5]);
            chk("R2 pc step", dbg_pc, 32'(4 * n));
            read_reg(n % 8, v);
            chk("R1 per-cycle register", v, m_reg[n % 8]);
            if (n == 10) begin
                // R11: strobes while running must be dropped
                dmem_load_en = 1'b1; dmem_load_idx = 6'd60; dmem_load_data = 32'hDEAD_BEEF;
                imem_load_en = 1'b1; imem_load_idx = 6'd30; imem_load_data = enc_r(1, 1, 3, 6'h20);
            end else begin
                dmem_load_en = 1'b0; imem_load_en = 1'b0;
            end
        end

        for (int i = 0; i < 8; i++) begin
            read_reg(i, v);
            chk("R1 final register", v, m_reg[i]);
        end
        read_reg(3, v); chk("R3 add r3", v, 32'd44);
        read_reg(3, v); chk("R11 imem strobe ignored (r3)", v, 32'd44);
        read_reg(5, v); chk("R3 add r5", v, 32'd49);
        read_reg(6, v); chk("R4 nand r6", v, 32'hFFFF_FFFE);
        read_reg(4, v); chk("R5 load r4", v, 32'hFFFF_FFF0);
        read_reg(2, v); chk("R5 load after store r2", v, 32'hFFFF_FFFE);
        read_reg(7, v); chk("R8 unknown opcode left r7", v, 32'd22);
        read_reg(6, v); chk("R8 unknown function left r6", v, 32'hFFFF_FFFE);
        read_reg(0, v); chk("R9 producer r0", v, 32'd33);
        read_reg(1, v); chk("R9 consumer two nops later r1", v, 32'd66);
        read_dmem(14, v); chk("R6 store word 14", v, 32'd22);
        read_dmem(10, v); chk("R7 negative offset word 10", v, 32'hFFFF_FFFE);
        read_dmem(9, v);  chk("R7 negative offset word 9", v, 32'd66);
        read_dmem(60, v); chk("R11 dmem strobe ignored", v, preload(60));
        for (int i = 0; i < WORDS; i++) begin
            read_dmem(i, v);
            chk("R12 data word", v, m_dmem[i]);
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule